// File: doc/BRIEF.md
# Virtual Address Region and Fault Checker

This block sits beside a processor's load/store and fetch path and decides what happens to each memory access from its virtual address, its privilege level and its kind (load, store or instruction fetch). In one combinational pass it first checks the address for misalignment against the access size. It then sorts the address into one of three classes: a privileged window that maps straight through, a window that user code may not touch, or an ordinary address that needs translation. For ordinary addresses it raises a request to an external translation lookup, which answers in the same cycle with hit, physical page number and read/write/execute rights. The block then grants the access with a physical address or names a fault cause.

On a fault the block updates a small set of fault-reporting registers at the next clock edge. These are the faulting address, the last cause, a flag telling data faults from fetch faults, and a page-table-entry pointer whose page-number field is loaded with the faulting page. The translation storage itself lives outside. A parameter builds the block without translation, and then every aligned access maps one-to-one.

Top module: `vfu_top`

## Requirements
- R1: With `MMU_EN` = 0, every valid aligned access is granted with `res_paddr` equal to `acc_vaddr`, `lk_req` stays 0, and the only possible fault is misalignment.
- R2: With `MMU_EN` = 1 and `acc_user` = 0, an aligned address at or above 0xC0000000 is granted one-to-one (`res_paddr` = `acc_vaddr`) without raising `lk_req`.
- R3: With `MMU_EN` = 1 and `acc_user` = 1, an aligned address at or above 0x80000000 faults with cause 2 (privileged address) and does not raise `lk_req`.
- R4: Any other valid aligned access raises `lk_req`. On a hit whose right matches the kind (`lk_rd` for a load, `lk_wr` for a store, `lk_ex` for a fetch), it is granted with `res_paddr` = {`lk_ppn`, `acc_vaddr`[11:0]`}. Kind encoding: 0 load, 1 store, 2 fetch.
- R5: On a hit without the matching right, the cause is 4 for a load, 5 for a store and 6 for a fetch.
- R6: On a lookup miss, the cause is 3.
- R7: Size encoding: 0 byte, 1 halfword, 2 word. A halfword with address bit 0 set, or a word with either of bits [1:0] set, faults with cause 1 before any region or lookup decision, and does not raise `lk_req`.
- R8: After any fault, `badaddr_q` holds the faulting address and `cause_q` holds the cause from the next cycle on.
- R9: After a fault with cause 3 to 6, `tlb_data_q` is 0 for a fetch and 1 for a load or store. `pteaddr_q`[21:2] holds `acc_vaddr`[31:12], `pteaddr_q`[31:22] keeps its previous value, and `pteaddr_q`[1:0] is 0.
- R10: When `acc_valid` is 0, `res_ok`, `res_fault` and `lk_req` are 0. Accesses that do not fault leave `badaddr_q`, `cause_q`, `tlb_data_q` and `pteaddr_q` unchanged, and faults with cause 1 or 2 leave `tlb_data_q` and `pteaddr_q` unchanged.
- R11: `pte_wr_en` loads `pte_wr_data` into `pteaddr_q`, except in a cycle with a cause 3 to 6 fault, where the fault update of R9 takes precedence.
- R12: Reset clears `badaddr_q`, `pteaddr_q`, `tlb_data_q` and `cause_q` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_vaddr | input | 32 | Virtual address of the access |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word |
| acc_user | input | 1 | 1 when the access runs at user privilege |
| lk_req | output | 1 | Translation lookup wanted for this access |
| lk_hit | input | 1 | Lookup found a mapping |
| lk_ppn | input | 20 | Physical page number from the lookup |
| lk_rd | input | 1 | Mapping allows reads |
| lk_wr | input | 1 | Mapping allows writes |
| lk_ex | input | 1 | Mapping allows execution |
| res_ok | output | 1 | Access granted |
| res_fault | output | 1 | Access faults |
| res_cause | output | 3 | Fault cause this cycle (0 when none) |
| res_paddr | output | 32 | Physical address when granted |
| pte_wr_en | input | 1 | Load the page-table-entry pointer |
| pte_wr_data | input | 32 | Value for the page-table-entry pointer |
| badaddr_q | output | 32 | Address of the last fault |
| pteaddr_q | output | 32 | Page-table-entry pointer |
| tlb_data_q | output | 1 | Last translation fault was a data access |
| cause_q | output | 3 | Cause of the last fault |

## Verification
The bench builds two copies of the block with the default 32-bit address, 4 KiB page and page-number field at bits [21:2]. One copy has `MMU_EN` = 1 and the other has `MMU_EN` = 0, and both are driven with the same stimulus. The sweep walks pages on both sides of the 0x80000000 and 0xC0000000 boundaries through every combination of kind, size, low address bits, privilege, hit and all eight permission patterns. This brings every cause code, the exact window edges and the misalignment priority within reach, together with the register history that follows each fault. The no-translation copy shows the identity mapping over the same addresses, and a directed cycle exercises the clash between a pointer write and a translation fault.

// File: rtl/vfu_pkg.sv
package vfu_pkg;

   typedef enum logic [1:0] {
      KIND_LOAD  = 2'd0,
      KIND_STORE = 2'd1,
      KIND_FETCH = 2'd2
   } acc_kind_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;

   typedef enum logic [2:0] {
      CZ_NONE     = 3'd0,
      CZ_MISALIGN = 3'd1,
      CZ_PRIV     = 3'd2,
      CZ_MISS     = 3'd3,
      CZ_RD       = 3'd4,
      CZ_WR       = 3'd5,
      CZ_EX       = 3'd6
   } cause_e;

endpackage

// File: rtl/vfu_align_chk.sv
module vfu_align_chk
   import vfu_pkg::*;
(
   input  logic [1:0] addr_low,
   input  logic [1:0] size,
   output logic       misaligned
);

   always_comb begin
      unique case (acc_size_e'(size))
         SZ_HALF: misaligned = addr_low[0];
         SZ_WORD: misaligned = |addr_low;
         default: misaligned = 1'b0;
      endcase
   end

endmodule

// File: rtl/vfu_region_dec.sv
module vfu_region_dec #(
   parameter int             VA_W        = 32,
   parameter bit             MMU_EN      = 1'b1,
   parameter logic [VA_W-1:0] USER_TOP    = 32'h8000_0000,
   parameter logic [VA_W-1:0] KERNEL_BASE = 32'hC000_0000
) (
   input  logic [VA_W-1:0] vaddr,
   input  logic            user,
   output logic            bypass,
   output logic            priv_fault
);

   generate
      if (MMU_EN) begin : g_xlat
         assign bypass     = !user && (vaddr >= KERNEL_BASE);
         assign priv_fault =  user && (vaddr >= USER_TOP);
      end else begin : g_flat
         logic unused_in;
         assign unused_in  = ^{vaddr, user};
         assign bypass     = 1'b1;
         assign priv_fault = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/vfu_perm_chk.sv
module vfu_perm_chk
   import vfu_pkg::*;
(
   input  logic [1:0] kind,
   input  logic       may_rd,
   input  logic       may_wr,
   input  logic       may_ex,
   output logic       allowed,
   output cause_e     deny_cause
);

   always_comb begin
      unique case (acc_kind_e'(kind))
         KIND_LOAD:  begin allowed = may_rd; deny_cause = CZ_RD; end
         KIND_STORE: begin allowed = may_wr; deny_cause = CZ_WR; end
         default:    begin allowed = may_ex; deny_cause = CZ_EX; end
      endcase
   end

endmodule

// File: rtl/vfu_top.sv
module vfu_top
   import vfu_pkg::*;
#(
   parameter int              VA_W        = 32,
   parameter int              PG_BITS     = 12,
   parameter int              PN_LSB      = 2,
   parameter bit              MMU_EN      = 1'b1,
   parameter logic [VA_W-1:0] USER_TOP    = 32'h8000_0000,
   parameter logic [VA_W-1:0] KERNEL_BASE = 32'hC000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [VA_W-1:0]   acc_vaddr,
   input  logic [1:0]        acc_kind,
   input  logic [1:0]        acc_size,
   input  logic              acc_user,
   output logic              lk_req,
   input  logic              lk_hit,
   input  logic [VA_W-PG_BITS-1:0] lk_ppn,
   input  logic              lk_rd,
   input  logic              lk_wr,
   input  logic              lk_ex,
   output logic              res_ok,
   output logic              res_fault,
   output logic [2:0]        res_cause,
   output logic [VA_W-1:0]   res_paddr,
   input  logic              pte_wr_en,
   input  logic [VA_W-1:0]   pte_wr_data,
   output logic [VA_W-1:0]   badaddr_q,
   output logic [VA_W-1:0]   pteaddr_q,
   output logic              tlb_data_q,
   output logic [2:0]        cause_q
);

   localparam int VPN_W   = VA_W - PG_BITS;
   localparam int PTB_LSB = PN_LSB + VPN_W;

   generate
      if (PN_LSB < 1 || PTB_LSB >= VA_W) begin : g_bad_field
         $error("vfu_top: page-number field does not fit the pointer register");
      end
      if (PG_BITS < 2 || PG_BITS >= VA_W) begin : g_bad_page
         $error("vfu_top: page size out of range");
      end
      if (KERNEL_BASE < USER_TOP) begin : g_bad_window
         $error("vfu_top: kernel window must lie inside the privileged range");
      end
   endgenerate

   logic   misaligned, bypass, priv_fault, allowed;
   cause_e deny_cause, cause_c;
   logic   ok_c, req_c;
   logic [VA_W-1:0] paddr_c;

   vfu_align_chk u_align (
      .addr_low   (acc_vaddr[1:0]),
      .size       (acc_size),
      .misaligned (misaligned)
   );

   vfu_region_dec #(
      .VA_W        (VA_W),
      .MMU_EN      (MMU_EN),
      .USER_TOP    (USER_TOP),
      .KERNEL_BASE (KERNEL_BASE)
   ) u_region (
      .vaddr      (acc_vaddr),
      .user       (acc_user),
      .bypass     (bypass),
      .priv_fault (priv_fault)
   );

   vfu_perm_chk u_perm (
      .kind       (acc_kind),
      .may_rd     (lk_rd),
      .may_wr     (lk_wr),
      .may_ex     (lk_ex),
      .allowed    (allowed),
      .deny_cause (deny_cause)
   );

   always_comb begin
      cause_c = CZ_NONE;
      ok_c    = 1'b0;
      req_c   = 1'b0;
      paddr_c = '0;
      if (acc_valid) begin
         if (misaligned) begin
            cause_c = CZ_MISALIGN;
         end else if (bypass) begin
            ok_c    = 1'b1;
            paddr_c = acc_vaddr;
         end else if (priv_fault) begin
            cause_c = CZ_PRIV;
         end else begin
            req_c = 1'b1;
            if (!lk_hit) begin
               cause_c = CZ_MISS;
            end else if (allowed) begin
               ok_c    = 1'b1;
               paddr_c = {lk_ppn, acc_vaddr[PG_BITS-1:0]};
            end else begin
               cause_c = deny_cause;
            end
         end
      end
   end

   logic fault_c, xlat_fault_c;
   assign fault_c      = (cause_c != CZ_NONE);
   assign xlat_fault_c = (cause_c == CZ_MISS) || (cause_c == CZ_RD) ||
                         (cause_c == CZ_WR)   || (cause_c == CZ_EX);

   assign lk_req    = req_c;
   assign res_ok    = ok_c;
   assign res_fault = fault_c;
   assign res_cause = cause_c;
   assign res_paddr = paddr_c;

   logic [VA_W-1:0] pte_fault_val;
   always_comb begin
      pte_fault_val                    = pteaddr_q;
      pte_fault_val[PN_LSB +: VPN_W]   = acc_vaddr[VA_W-1 -: VPN_W];
      pte_fault_val[PN_LSB-1:0]        = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         badaddr_q  <= '0;
         pteaddr_q  <= '0;
         tlb_data_q <= 1'b0;
         cause_q    <= '0;
      end else begin
         if (fault_c) begin
            badaddr_q <= acc_vaddr;
            cause_q   <= cause_c;
         end
         if (xlat_fault_c) begin
            tlb_data_q <= (acc_kind_e'(acc_kind) != KIND_FETCH);
            pteaddr_q  <= pte_fault_val;
         end else if (pte_wr_en) begin
            pteaddr_q  <= pte_wr_data;
         end
      end
   end

endmodule

// File: rtl/vfu_checker.sv
module vfu_checker #(
   parameter int              VA_W        = 32,
   parameter int              PG_BITS     = 12,
   parameter int              PN_LSB      = 2,
   parameter bit              MMU_EN      = 1'b1,
   parameter logic [VA_W-1:0] KERNEL_BASE = 32'hC000_0000
) (
   input logic            clk,
   input logic            rst_n,
   input logic            acc_valid,
   input logic [VA_W-1:0] acc_vaddr,
   input logic [1:0]      acc_size,
   input logic            acc_user,
   input logic            lk_req,
   input logic            res_ok,
   input logic            res_fault,
   input logic [2:0]      res_cause,
   input logic [VA_W-1:0] badaddr_q,
   input logic [VA_W-1:0] pteaddr_q,
   input logic [2:0]      cause_q
);

   localparam int VPN_W   = VA_W - PG_BITS;
   localparam int PTB_LSB = PN_LSB + VPN_W;

   logic xlat_f;
   assign xlat_f = res_fault && (res_cause >= 3'd3);

   // R4
   a_r4_grant_fault_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_ok && res_fault));

   // R7
   a_r7_misalign_first: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_size == 2'd2 && acc_vaddr[1:0] != 2'b00)
      |-> (res_fault && res_cause == 3'd1 && !lk_req));

   // R8
   a_r8_badaddr_capture: assert property (@(posedge clk) disable iff (!rst_n)
      res_fault |=> (badaddr_q == $past(acc_vaddr) && cause_q == $past(res_cause)));

   // R9
   a_r9_pte_page_load: assert property (@(posedge clk) disable iff (!rst_n)
      xlat_f |=> (pteaddr_q[PN_LSB +: VPN_W] == $past(acc_vaddr[VA_W-1 -: VPN_W])));

   a_r9_pte_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
      xlat_f |=> (pteaddr_q[VA_W-1:PTB_LSB] == $past(pteaddr_q[VA_W-1:PTB_LSB])));

   // R10
   a_r10_quiet_when_ok: assert property (@(posedge clk) disable iff (!rst_n)
      !res_fault |=> ($stable(badaddr_q) && $stable(cause_q)));

   a_r10_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (!res_ok && !res_fault && !lk_req));

   generate
      if (MMU_EN) begin : g_mmu_props
         // R2
         a_r2_bypass_no_lookup: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid && !acc_user && acc_vaddr >= KERNEL_BASE) |-> !lk_req);
      end else begin : g_flat_props
         // R1
         a_r1_flat_no_lookup: assert property (@(posedge clk) disable iff (!rst_n)
            !lk_req);
      end
   endgenerate

endmodule

bind vfu_top vfu_checker #(
   .VA_W        (VA_W),
   .PG_BITS     (PG_BITS),
   .PN_LSB      (PN_LSB),
   .MMU_EN      (MMU_EN),
   .KERNEL_BASE (KERNEL_BASE)
) u_vfu_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_vaddr (acc_vaddr),
   .acc_size  (acc_size),
   .acc_user  (acc_user),
   .lk_req    (lk_req),
   .res_ok    (res_ok),
   .res_fault (res_fault),
   .res_cause (res_cause),
   .badaddr_q (badaddr_q),
   .pteaddr_q (pteaddr_q),
   .cause_q   (cause_q)
);

// File: tb/vfu_top_test.sv
`timescale 1ns/1ps
module vfu_top_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_vaddr = '0;
   logic [1:0]  acc_kind = '0;
   logic [1:0]  acc_size = '0;
   logic        acc_user = 1'b0;
   logic        lk_hit = 1'b0;
   logic [19:0] lk_ppn = '0;
   logic        lk_rd = 1'b0, lk_wr = 1'b0, lk_ex = 1'b0;
   logic        pte_wr_en = 1'b0;
   logic [31:0] pte_wr_data = '0;

   logic        m_req, m_ok, m_fault, m_data;
   logic [2:0]  m_cause, m_cq;
   logic [31:0] m_paddr, m_bad, m_pte;
   logic        f_req, f_ok, f_fault, f_data;
   logic [2:0]  f_cause, f_cq;
   logic [31:0] f_paddr, f_bad, f_pte;

   always #2.5 clk = ~clk;

   vfu_top #(.MMU_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_vaddr(acc_vaddr),
      .acc_kind(acc_kind), .acc_size(acc_size), .acc_user(acc_user),
      .lk_req(m_req), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_rd(lk_rd),
      .lk_wr(lk_wr), .lk_ex(lk_ex), .res_ok(m_ok), .res_fault(m_fault),
      .res_cause(m_cause), .res_paddr(m_paddr), .pte_wr_en(pte_wr_en),
      .pte_wr_data(pte_wr_data), .badaddr_q(m_bad), .pteaddr_q(m_pte),
      .tlb_data_q(m_data), .cause_q(m_cq));

   vfu_top #(.MMU_EN(1'b0)) uut_flat (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_vaddr(acc_vaddr),
      .acc_kind(acc_kind), .acc_size(acc_size), .acc_user(acc_user),
      .lk_req(f_req), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_rd(lk_rd),
      .lk_wr(lk_wr), .lk_ex(lk_ex), .res_ok(f_ok), .res_fault(f_fault),
      .res_cause(f_cause), .res_paddr(f_paddr), .pte_wr_en(pte_wr_en),
      .pte_wr_data(pte_wr_data), .badaddr_q(f_bad), .pteaddr_q(f_pte),
      .tlb_data_q(f_data), .cause_q(f_cq));

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // model state
   logic [31:0] e_bad, e_pte, ef_bad, ef_pte;
   logic [2:0]  e_cq, ef_cq;
   logic        e_data;

   task automatic chk(input bit good, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_cmp++;
      if (!good) begin
         n_bad++;
         if (n_bad < 20)
            $display("FAIL %s: actual %h expected %h (va=%h kind=%0d size=%0d user=%0d hit=%0d)",
                     tag, act, exp, acc_vaddr, acc_kind, acc_size, acc_user, lk_hit);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // expected combinational result for the translating copy
   task automatic expect_mmu(output logic ok, output logic [2:0] c,
                             output logic req, output logic [31:0] pa);
      logic mis;
      ok = 0; c = 0; req = 0; pa = 0;
      mis = (acc_size == 2'd1 && acc_vaddr[0]) || (acc_size == 2'd2 && acc_vaddr[1:0] != 0);
      if (!acc_valid) begin
      end else if (mis) c = 3'd1;
      else if (!acc_user && acc_vaddr >= 32'hC000_0000) begin ok = 1; pa = acc_vaddr; end
      else if (acc_user && acc_vaddr >= 32'h8000_0000) c = 3'd2;
      else begin
         req = 1;
         if (!lk_hit) c = 3'd3;
         else if ((acc_kind == 0 && lk_rd) || (acc_kind == 1 && lk_wr) ||
                  (acc_kind == 2 && lk_ex)) begin
            ok = 1; pa = {lk_ppn, acc_vaddr[11:0]};
         end else c = 3'd4 + {1'b0, acc_kind};
      end
   endtask

   task automatic run_case();
      logic eok, ereq, fok, fmis;
      logic [2:0] ec, fc;
      logic [31:0] epa;
      @(negedge clk);
      #0.5;
      expect_mmu(eok, ec, ereq, epa);
      fmis = (acc_size == 2'd1 && acc_vaddr[0]) || (acc_size == 2'd2 && acc_vaddr[1:0] != 0);
      fok  = acc_valid && !fmis;
      fc   = (acc_valid && fmis) ? 3'd1 : 3'd0;
      // R2 R3 R4 R5 R6 R7: grant, cause and lookup request of the translating copy
      chk(m_ok == eok,      "R4 res_ok",   {31'd0, m_ok}, {31'd0, eok});
      chk(m_fault == (ec != 0), "R5 res_fault", {31'd0, m_fault}, {31'd0, ec != 0});
      chk(m_cause == ec,    "R6 res_cause", {29'd0, m_cause}, {29'd0, ec});
      chk(m_req == ereq,    "R3 lk_req",   {31'd0, m_req}, {31'd0, ereq});
      if (eok) chk(m_paddr == epa, "R2 res_paddr", m_paddr, epa);
      // R1 R7: flat copy
      chk(f_ok == fok && f_cause == fc && !f_req, "R1 flat grant",
          {f_req, 27'd0, f_cause, f_ok}, {1'b0, 27'd0, fc, fok});
      if (fok) chk(f_paddr == acc_vaddr, "R1 flat paddr", f_paddr, acc_vaddr);
      @(posedge clk);
      #0.5;
      if (ec != 0) begin e_bad = acc_vaddr; e_cq = ec; end
      if (ec >= 3) begin
         e_data = (acc_kind != 2'd2);
         e_pte  = {e_pte[31:22], acc_vaddr[31:12], 2'b00};
      end else if (pte_wr_en) e_pte = pte_wr_data;
      if (fc != 0) begin ef_bad = acc_vaddr; ef_cq = fc; end
      if (pte_wr_en) ef_pte = pte_wr_data;
      // R8 R9 R10 R11
      chk(m_bad == e_bad,   "R8 badaddr_q", m_bad, e_bad);
      chk(m_cq == e_cq,     "R8 cause_q",   {29'd0, m_cq}, {29'd0, e_cq});
      chk(m_pte == e_pte,   "R9 pteaddr_q", m_pte, e_pte);
      chk(m_data == e_data, "R9 tlb_data_q", {31'd0, m_data}, {31'd0, e_data});
      chk(f_bad == ef_bad && f_cq == ef_cq, "R10 flat fault regs",
          {f_cq, f_bad[28:0]}, {ef_cq, ef_bad[28:0]});
      chk(f_pte == ef_pte,  "R11 flat pteaddr_q", f_pte, ef_pte);
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [31:0] pages [6];
      pages[0] = 32'h0000_1000; pages[1] = 32'h7FFF_F000; pages[2] = 32'h8000_0000;
      pages[3] = 32'hBFFF_F000; pages[4] = 32'hC000_0000; pages[5] = 32'hFFFF_F000;
      e_bad = 0; e_pte = 0; e_cq = 0; e_data = 0; ef_bad = 0; ef_pte = 0; ef_cq = 0;
      repeat (3) @(posedge clk);
      #0.5;
      // R12 reset state
      chk(m_bad == 0 && m_pte == 0 && m_cq == 0 && !m_data, "R12 reset regs",
          m_bad | m_pte, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 pointer write
      pte_wr_en = 1'b1; pte_wr_data = 32'hABC0_1237;
      run_case();
      // R11 clash: write and translation miss in one cycle, fault wins
      acc_valid = 1'b1; acc_vaddr = 32'h0000_5004; acc_kind = 2'd1; acc_size = 2'd2;
      acc_user = 1'b1; lk_hit = 1'b0; pte_wr_data = 32'h1111_1111;
      run_case();
      pte_wr_en = 1'b0;
      // R10 idle cycle with a fault-provoking address
      acc_valid = 1'b0; acc_vaddr = 32'h9000_0001;
      run_case();
      acc_valid = 1'b1;

      for (int pg = 0; pg < 6; pg++)
         for (int lo = 0; lo < 4; lo++)
            for (int k = 0; k < 3; k++)
               for (int sz = 0; sz < 3; sz++)
                  for (int u = 0; u < 2; u++)
                     for (int h = 0; h < 2; h++)
                        for (int p = 0; p < 8; p++) begin
                           acc_vaddr = pages[pg] | 32'h5A0 | 32'(lo);
                           acc_kind  = 2'(k);
                           acc_size  = 2'(sz);
                           acc_user  = u[0];
                           lk_hit    = h[0];
                           lk_ppn    = acc_vaddr[31:12] ^ 20'h5_A5A3;
                           {lk_ex, lk_wr, lk_rd} = 3'(p);
                           run_case();
                        end
      summary();
   end

endmodule